// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Selectable Output Timing

This block is a single-port synchronous memory. Its write data trails the write command by one clock, so a read can follow a write with no idle cycle between them. Address, chip select, write enable and one active-low enable per byte lane are sampled on the rising clock edge. The data of a write goes into a pending-entry register when it arrives. That entry is moved into the array only when the next write command is accepted. A read whose address matches the pending entry takes the enabled lanes of that entry in place of the array contents, so a read always sees the latest write.

A two-bit mode input selects how read data reaches the output. In flow-through mode the data follows the registered address through logic. In registered mode it comes out of a flop one rising edge later. In latched mode it is captured and presented on the falling clock edge. The bus is modelled as separate data-in, data-out and drive-enable signals. An asynchronous output-enable input and a sleep input can each switch the drive off.

Top module: `lw_sram`

## Requirements
- R1: When reset is released, sleep_i is low and cs_n_i is low, a rising edge with we_n_i high starts a read of the word at addr_i.
- R2: When reset is released, sleep_i is low and cs_n_i is low, a rising edge with we_n_i low starts a write. Lane i (data bits 9*i+8 down to 9*i) is stored only if be_n_i[i] is low. The data for the write is taken from wdata_i at the next rising edge.
- R3: A write command with be_n_i = 4'b1111 is an aborted write and changes no stored word.
- R4: A read of an address written by any earlier write returns that write's lanes merged over older contents, including a read issued at the edge right after the write command.
- R5: At an edge where cs_n_i is high, no operation is started, and the cycle that edge governs shows rdata_en_o low.
- R6: At an edge where sleep_i is high, no operation is started, whatever the other inputs are, and that cycle shows rdata_en_o low.
- R7: With mode_i = 2'b01 (registered), and also with the alias 2'b11, read data and rdata_en_o appear one clock later than in flow-through mode. They change only on a rising edge.
- R8: With mode_i = 2'b00 (flow-through), the data of a read sampled at edge n is valid on rdata_o with rdata_en_o high before edge n+1.
- R9: With mode_i = 2'b10 (latched), the output of a read sampled at edge n changes at the falling edge after edge n. Between edge n and that falling edge the output keeps its earlier value.
- R10: While oe_n_i is high, rdata_en_o is low at once, without waiting for a clock edge.
- R11: In flow-through and latched modes, the cycle after a write command shows rdata_en_o low, so that the write data can be driven.
- R12: During reset rdata_en_o is low and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Power-down request, active high |
| cs_n_i | input | 1 | Chip select, active low |
| we_n_i | input | 1 | Write enable, active low |
| be_n_i | input | LANES | Lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| mode_i | input | 2 | Output timing: 00 flow-through, 01/11 registered, 10 latched |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | LANES*LANE_W | Write data, driven in the cycle after its command |
| rdata_o | output | LANES*LANE_W | Read data |
| rdata_en_o | output | 1 | High when the block would drive the bus |

## Verification
The assertions check on every clock several properties. The output stays disabled while oe_n_i is high. The bus is released after a deselect, a sleep cycle or a write in flow-through and latched modes. A write loads the pending entry with the complement of its lane enables, and an aborted write loads an empty mask. Only the bench scenarios can show that the read data is right. They follow mixed write, read and aborted-write sequences and check forwarding from the pending entry, including partial-lane merges. They also check the extra cycle of latency in registered mode and that the latched output holds its value until the falling edge.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

   typedef enum logic [1:0] {
      OM_FLOW    = 2'b00,
      OM_REG     = 2'b01,
      OM_LATCH   = 2'b10,
      OM_REG_ALT = 2'b11
   } omode_e;

endpackage

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [LANES-1:0]          wr_mask,
   input  logic [LANES*LANE_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0]         rd_addr,
   output logic [LANES*LANE_W-1:0]   rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && wr_mask[g])
            mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end

      assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
   end

endmodule

// File: rtl/lw_sram_store.sv
module lw_sram_store #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cmd_wr,
   input  logic [ADDR_W-1:0]         cmd_addr,
   input  logic [LANES-1:0]          cmd_mask,
   input  logic                      data_phase,
   input  logic [LANES*LANE_W-1:0]   wdata,
   output logic                      commit_en,
   output logic [ADDR_W-1:0]         commit_addr,
   output logic [LANES-1:0]          commit_mask,
   output logic [LANES*LANE_W-1:0]   commit_data,
   output logic                      pend_valid,
   output logic [ADDR_W-1:0]         pend_addr,
   output logic [LANES-1:0]          pend_mask,
   output logic [LANES*LANE_W-1:0]   pend_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_addr  <= '0;
         pend_mask  <= '0;
      end else if (cmd_wr) begin
         pend_valid <= 1'b1;
         pend_addr  <= cmd_addr;
         pend_mask  <= cmd_mask;
      end
   end

   always_ff @(posedge clk) begin
      if (data_phase)
         pend_data <= wdata;
   end

   // The older entry leaves as the new one arrives; its data may be on the bus right now.
   assign commit_en   = cmd_wr && pend_valid;
   assign commit_addr = pend_addr;
   assign commit_mask = pend_mask;
   assign commit_data = data_phase ? wdata : pend_data;

endmodule

// File: rtl/lw_sram_out.sv
module lw_sram_out
   import lw_sram_pkg::*;
#(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              rd_stage,
   input  logic [DATA_W-1:0] flow_data,
   input  logic              oe_n,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_en
);
   omode_e            m;
   logic              rr_en, rl_en, sel_en;
   logic [DATA_W-1:0] rr_data, rl_data;

   assign m = omode_e'(mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_en   <= 1'b0;
         rr_data <= '0;
      end else begin
         rr_en   <= rd_stage;
         rr_data <= flow_data;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rl_en   <= 1'b0;
         rl_data <= '0;
      end else begin
         rl_en   <= rd_stage;
         rl_data <= flow_data;
      end
   end

   always_comb begin
      case (m)
         OM_FLOW:  begin sel_en = rd_stage; rdata = flow_data; end
         OM_LATCH: begin sel_en = rl_en;    rdata = rl_data;   end
         default:  begin sel_en = rr_en;    rdata = rr_data;   end
      endcase
   end

   assign rdata_en = sel_en && !oe_n;

endmodule

// File: rtl/lw_sram.sv
module lw_sram
   import lw_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sleep_i,
   input  logic                      cs_n_i,
   input  logic                      we_n_i,
   input  logic [LANES-1:0]          be_n_i,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic [1:0]                mode_i,
   input  logic                      oe_n_i,
   input  logic [LANES*LANE_W-1:0]   wdata_i,
   output logic [LANES*LANE_W-1:0]   rdata_o,
   output logic                      rdata_en_o
);
   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("lw_sram: ADDR_W out of range");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("lw_sram: lane geometry must be non-zero");
   end

   logic              live, cmd_wr;
   logic              rd_q, wr_q;
   logic [ADDR_W-1:0] addr_q;

   logic              commit_en;
   logic [ADDR_W-1:0] commit_addr;
   logic [LANES-1:0]  commit_mask;
   logic [DATA_W-1:0] commit_data;
   logic              pend_valid;
   logic [ADDR_W-1:0] pend_addr;
   logic [LANES-1:0]  pend_mask;
   logic [DATA_W-1:0] pend_data;
   logic [DATA_W-1:0] arr_data, flow_data;
   logic              hit;

   assign live   = !sleep_i && !cs_n_i;
   assign cmd_wr = live && !we_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= 1'b0;
         wr_q   <= 1'b0;
         addr_q <= '0;
      end else begin
         rd_q <= live && we_n_i;
         wr_q <= cmd_wr;
         if (live)
            addr_q <= addr_i;
      end
   end

   lw_sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_wr      (cmd_wr),
      .cmd_addr    (addr_i),
      .cmd_mask    (~be_n_i),
      .data_phase  (wr_q),
      .wdata       (wdata_i),
      .commit_en   (commit_en),
      .commit_addr (commit_addr),
      .commit_mask (commit_mask),
      .commit_data (commit_data),
      .pend_valid  (pend_valid),
      .pend_addr   (pend_addr),
      .pend_mask   (pend_mask),
      .pend_data   (pend_data)
   );

   lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
      .clk     (clk),
      .wr_en   (commit_en),
      .wr_addr (commit_addr),
      .wr_mask (commit_mask),
      .wr_data (commit_data),
      .rd_addr (addr_q),
      .rd_data (arr_data)
   );

   assign hit = pend_valid && (pend_addr == addr_q);

   for (genvar g = 0; g < LANES; g++) begin : g_fwd
      assign flow_data[g*LANE_W +: LANE_W] = (hit && pend_mask[g])
         ? pend_data[g*LANE_W +: LANE_W] : arr_data[g*LANE_W +: LANE_W];
   end

   lw_sram_out #(.DATA_W(DATA_W)) i_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_i),
      .rd_stage  (rd_q),
      .flow_data (flow_data),
      .oe_n      (oe_n_i),
      .rdata     (rdata_o),
      .rdata_en  (rdata_en_o)
   );

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sleep_i,
   input logic             cs_n_i,
   input logic             we_n_i,
   input logic [LANES-1:0] be_n_i,
   input logic [1:0]       mode_i,
   input logic             oe_n_i,
   input logic             rdata_en_o,
   input logic             pend_valid,
   input logic [LANES-1:0] pend_mask
);
   logic wr_cmd;
   assign wr_cmd = !sleep_i && !cs_n_i && !we_n_i;

   p_oe_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n_i |-> !rdata_en_o);

   p_deselect_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_i && !sleep_i && mode_i == 2'b00) |=> (!rdata_en_o || mode_i != 2'b00));

   p_sleep_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && mode_i == 2'b00) |=> (!rdata_en_o || mode_i != 2'b00));

   p_write_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && (mode_i == 2'b00 || mode_i == 2'b10))
      |=> (!rdata_en_o || mode_i != $past(mode_i)));

   p_abort_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && (&be_n_i)) |=> (pend_valid && pend_mask == '0));

   p_write_pends_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && !(&be_n_i)) |=> (pend_valid && pend_mask == ~$past(be_n_i)));

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r12: assert (!rdata_en_o && !pend_valid)
            else $error("reset state violated");
      end
   end

endmodule

bind lw_sram lw_sram_chk #(.LANES(LANES)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sleep_i    (sleep_i),
   .cs_n_i     (cs_n_i),
   .we_n_i     (we_n_i),
   .be_n_i     (be_n_i),
   .mode_i     (mode_i),
   .oe_n_i     (oe_n_i),
   .rdata_en_o (rdata_en_o),
   .pend_valid (pend_valid),
   .pend_mask  (pend_mask)
);

// File: tb/test_lw_sram.sv
module test_lw_sram;
   localparam int PERIOD = 10;
   localparam int AW = 6;
   localparam int DW = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_i = 1'b0, cs_n_i = 1'b1, we_n_i = 1'b1, oe_n_i = 1'b0;
   logic [3:0]    be_n_i = 4'hF;
   logic [AW-1:0] addr_i = '0;
   logic [1:0]    mode_i = 2'b00;
   logic [DW-1:0] wdata_i = '0;
   logic [DW-1:0] rdata_o;
   logic          rdata_en_o;

   lw_sram i_lw_sram (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .cs_n_i(cs_n_i), .we_n_i(we_n_i),
      .be_n_i(be_n_i), .addr_i(addr_i), .mode_i(mode_i), .oe_n_i(oe_n_i),
      .wdata_i(wdata_i), .rdata_o(rdata_o), .rdata_en_o(rdata_en_o)
   );

   always #(PERIOD/2) clk = ~clk;

   typedef struct {
      int            due;
      logic          en;
      logic [DW-1:0] d;
      string         tag;
   } exp_t;

   exp_t          q[$];
   logic [DW-1:0] refm [64];
   logic [DW-1:0] nxt_wd = '0;
   int            cyc = 0;
   int            checks = 0;
   int            fails = 0;
   int            last_cyc = -10;
   logic          last_en;
   logic [DW-1:0] last_d;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, expv, cyc);
      end
   endtask

   // kind: 0 deselect, 1 read, 2 write, 3 write attempt under sleep
   task automatic op(input int kind, input logic [AW-1:0] a, input logic [3:0] ben,
                     input logic [DW-1:0] d, input bit probe, input string tag);
      exp_t e;
      @(posedge clk); #2;
      wdata_i = nxt_wd;
      sleep_i = (kind == 3);
      cs_n_i  = (kind == 0);
      we_n_i  = (kind == 1);
      be_n_i  = ben;
      addr_i  = a;
      e.en = 1'b0;
      e.d  = '0;
      if (kind == 1) begin
         e.en = 1'b1;
         e.d  = refm[a];
      end
      if (kind == 2) begin
         for (int i = 0; i < 4; i++)
            if (!ben[i]) refm[a][i*9 +: 9] = d[i*9 +: 9];
      end
      nxt_wd = d;
      e.due = (mode_i[0]) ? cyc + 2 : cyc + 1;
      e.tag = tag;
      if (tag != "") q.push_back(e);
      if (probe) begin
         #6 oe_n_i = 1'b1;
         #1 check(rdata_en_o == 1'b0, "R10 oe_n high forces drive off", {35'd0, rdata_en_o}, '0);
         oe_n_i = 1'b0;
      end
   endtask

   task automatic drain();
      for (int i = 0; i < 4; i++) op(0, '0, 4'hF, '0, 1'b0, "");
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(posedge clk);
         #3;
         if (mode_i == 2'b10 && last_cyc == cyc - 1)
            check(rdata_en_o == last_en && (!last_en || rdata_o == last_d),
                  "R9 latched output holds before falling edge", rdata_o, last_d);
         #4;
         if (q.size() > 0 && q[0].due < cyc) begin
            check(1'b0, {q[0].tag, " missed"}, '0, q[0].d);
            void'(q.pop_front());
         end
         if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            check(rdata_en_o == e.en, {e.tag, " enable"}, {35'd0, rdata_en_o}, {35'd0, e.en});
            if (e.en)
               check(rdata_o == e.d, {e.tag, " data"}, rdata_o, e.d);
            last_cyc = cyc;
            last_en  = rdata_en_o;
            last_d   = rdata_o;
         end
      end
   end

   initial begin
      #(PERIOD * 5000);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #7;
      check(rdata_en_o == 1'b0, "R12 drive off in reset", {35'd0, rdata_en_o}, '0);
      rst_n = 1'b1;

      // flow-through
      mode_i = 2'b00;
      op(2, 6'd1, 4'h0, 36'h1_2345_6789, 0, "R11 R2 write a1");
      op(2, 6'd2, 4'h0, 36'hA_BCDE_F012, 0, "R11 R2 write a2");
      op(2, 6'd3, 4'h0, 36'h5_5555_5555, 0, "R11 R2 write a3");
      op(1, 6'd1, 4'hF, '0, 0, "R1 R8 read a1");
      op(1, 6'd2, 4'hF, '0, 0, "R1 R8 read a2");
      op(1, 6'd3, 4'hF, '0, 0, "R4 read pending a3");
      op(2, 6'd3, 4'b1010, 36'hF_0F0F_0F0F, 0, "R11 partial write a3");
      op(1, 6'd3, 4'hF, '0, 0, "R4 merged forward a3");
      op(0, '0, 4'hF, '0, 0, "R5 deselect");
      op(1, 6'd3, 4'hF, '0, 0, "R4 R2 lane merge a3");
      op(2, 6'd2, 4'hF, 36'hD_EADB_EEF0, 0, "R3 aborted write");
      op(1, 6'd2, 4'hF, '0, 0, "R3 a2 unchanged");
      op(0, '0, 4'hF, '0, 0, "R5 deselect");
      op(3, 6'd1, 4'h0, 36'h0_0000_0000, 0, "R6 sleep cycle");
      op(1, 6'd1, 4'hF, '0, 0, "R6 a1 unchanged");
      op(1, 6'd2, 4'hF, '0, 1, "R8 read a2");
      op(0, '0, 4'hF, '0, 0, "R5 deselect");
      drain();

      // registered
      mode_i = 2'b01;
      drain();
      op(1, 6'd1, 4'hF, '0, 0, "R7 registered read a1");
      op(2, 6'd4, 4'h0, 36'h3_1415_9265, 0, "R7 write a4");
      op(1, 6'd4, 4'hF, '0, 0, "R7 R4 read a4");
      op(1, 6'd3, 4'hF, '0, 0, "R7 read a3");
      op(0, '0, 4'hF, '0, 0, "R7 R5 deselect");
      op(1, 6'd2, 4'hF, '0, 0, "R7 read a2");
      drain();

      // latched
      mode_i = 2'b10;
      drain();
      op(2, 6'd5, 4'h0, 36'h2_7182_8182, 0, "R11 latched write a5");
      op(1, 6'd3, 4'hF, '0, 0, "R9 read a3");
      op(2, 6'd5, 4'b1001, 36'h8_8888_8888, 0, "R11 latched partial a5");
      op(1, 6'd5, 4'hF, '0, 0, "R9 R4 read a5");
      op(1, 6'd1, 4'hF, '0, 0, "R9 read a1");
      op(1, 6'd2, 4'hF, '0, 0, "R9 read a2");
      drain();

      // registered alias
      mode_i = 2'b11;
      drain();
      op(1, 6'd4, 4'hF, '0, 0, "R7 alias read a4");
      op(1, 6'd5, 4'hF, '0, 0, "R7 alias read a5");
      drain();

      check(q.size() == 0, "R1 scoreboard drained", q.size(), '0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule